// File: doc/BRIEF.md
# Program Sequencer with Dual Loop Counters

The sequencer holds the 16-bit instruction pointer of a small processor and two 16-bit loop counters. Each cycle the instruction pointer either holds, steps by one on a fetch strobe, takes a value written through the register port, vectors to an interrupt routine, or resolves a decrement-and-branch loop operation. The loop operation decrements the chosen counter. It jumps to the target carried by the instruction while the decremented count is nonzero, and falls through to the next sequential address once the count reaches zero.

Each cycle a priority decoder in `seq_op_dec` picks one operation class. The enumerated operations are:

- `OP_HOLD`: nothing requested.
- `OP_STEP`: fetch strobe alone.
- `OP_LOAD`: register write to the pointer.
- `OP_VECTOR`: interrupt acknowledge.
- `OP_LOOP_TAKEN`: loop operation with a nonzero decremented count.
- `OP_LOOP_EXIT`: loop operation with a zero decremented count.

A single register process moves the pointer from its current value to the value that operation selects. A separate output process registers the branch-taken flag. Every operation returns to the same decision point the next cycle; there are no multi-cycle sequences. Instruction decode, program memory, interrupt arbitration and return-address stacking are handled outside the block.

Top module: `prog_seq`

## Requirements
- R1: After reset the fetch address is 8000h, both loop counters read 0000h, the vector register reads 0020h and the branch-taken flag is low.
- R2: A fetch strobe with no other request advances the fetch address by one on the next cycle, wrapping from FFFFh to 0000h. With no request at all, the address holds.
- R3: A write with select code 00 loads the fetch address with the write data on the next cycle. It wins over a fetch strobe in the same cycle.
- R4: Write select 01 loads loop counter 0 and select 10 loads loop counter 1. Select 11 addresses the read-only vector register: it changes neither the fetch address, nor the counters, nor the vector value 0020h.
- R5: An accepted loop request decrements the selected counter by one, modulo 2^16 (0000h becomes FFFFh). Loop select 0 picks counter 0 and select 1 picks counter 1. The other counter is unchanged.
- R6: After an accepted loop request, if the decremented value is nonzero, the next fetch address is the loop target and the branch-taken flag is high for that one cycle. Otherwise the address advances by one and the flag is low.
- R7: An interrupt acknowledge sets the next fetch address to the vector value plus the zero-extended 4-bit offset. It overrides a pointer write, a loop request and a fetch in the same cycle, and a loop request in that cycle leaves its counter unchanged.
- R8: A loop request in a cycle that also writes the pointer, or writes the selected counter, is dropped: the write takes effect, and the counter is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Program fetch strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Write target: 00 pointer, 01 counter 0, 10 counter 1, 11 vector (read-only) |
| wr_data_i | input | 16 | Write data |
| loop_req_i | input | 1 | Decrement-and-branch request |
| loop_sel_i | input | 1 | Counter chosen by the loop request |
| loop_target_i | input | 16 | Branch target of the loop request |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_offs_i | input | 4 | Offset of the acknowledged interrupt |
| fetch_addr_o | output | 16 | Current instruction pointer / fetch address |
| lc0_o | output | 16 | Loop counter 0 read-back |
| lc1_o | output | 16 | Loop counter 1 read-back |
| ivec_o | output | 16 | Interrupt vector read-back |
| branch_taken_o | output | 1 | Loop branch taken in the previous cycle |

## Verification
The hardest situations to reach are the coincidences: a loop request on the same cycle as a write to its own counter, a pointer write, or an interrupt. Also hard to reach is a counter that starts at zero and wraps to FFFFh, which then takes the branch. The vector table reaches these through a scripted sequence. It first loads the counters to small values and runs them down to the exit case. It then keeps looping the exhausted counter so that it wraps. Finally it stacks writes and interrupts onto loop requests cycle by cycle and compares the pointer, both counters and the flag after every step.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Register write targets
    typedef enum logic [1:0] {
        SEL_IP  = 2'b00,
        SEL_LC0 = 2'b01,
        SEL_LC1 = 2'b10,
        SEL_VEC = 2'b11
    } wr_sel_e;

    // Operation class chosen each cycle for the instruction pointer
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_LOAD,
        OP_VECTOR,
        OP_LOOP_TAKEN,
        OP_LOOP_EXIT
    } op_e;

endpackage

// File: rtl/seq_loop_ctr.sv
module seq_loop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         dec_en,
    output logic [W-1:0] cnt_o,
    output logic         nz_after_dec_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else if (dec_en) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o          = cnt_q;
    assign nz_after_dec_o = (cnt_q != W'(1));

endmodule

// File: rtl/seq_op_dec.sv
module seq_op_dec
    import seq_pkg::*;
(
    input  logic fetch,
    input  logic wr_ip,
    input  logic wr_lc_hit,
    input  logic loop_req,
    input  logic irq,
    input  logic dec_nz,
    output op_e  op,
    output logic loop_ok
);

    always_comb begin
        loop_ok = loop_req && !irq && !wr_ip && !wr_lc_hit;
        if (irq) begin
            op = OP_VECTOR;
        end else if (wr_ip) begin
            op = OP_LOAD;
        end else if (loop_ok) begin
            op = dec_nz ? OP_LOOP_TAKEN : OP_LOOP_EXIT;
        end else if (fetch) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import seq_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          OFFS_W     = 4,
    parameter logic [15:0] RESET_IP   = 16'h8000,
    parameter logic [15:0] IVEC_RESET = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [AW-1:0]     wr_data_i,
    input  logic              loop_req_i,
    input  logic              loop_sel_i,
    input  logic [AW-1:0]     loop_target_i,
    input  logic              irq_ack_i,
    input  logic [OFFS_W-1:0] irq_offs_i,
    output logic [AW-1:0]     fetch_addr_o,
    output logic [AW-1:0]     lc0_o,
    output logic [AW-1:0]     lc1_o,
    output logic [AW-1:0]     ivec_o,
    output logic              branch_taken_o
);

    localparam int NUM_LC = 2;

    logic [AW-1:0]   ip_q;
    logic [AW-1:0]   ip_d;
    logic [AW-1:0]   ivec_q;
    logic            bt_q;
    op_e             op;
    logic            loop_ok;
    logic            wr_ip;
    logic [NUM_LC-1:0] wr_hit;
    logic [NUM_LC-1:0] dec_en;
    logic [NUM_LC-1:0] nz;
    logic [AW-1:0]   lc_val [NUM_LC];

    assign wr_ip = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_IP);

    for (genvar g = 0; g < NUM_LC; g++) begin : g_lc
        assign wr_hit[g] = wr_en_i && (wr_sel_i == 2'(g + 1));
        assign dec_en[g] = loop_ok && (loop_sel_i == 1'(g));
        seq_loop_ctr #(.W(AW)) i_ctr (
            .clk            (clk),
            .rst_n          (rst_n),
            .wr_en          (wr_hit[g]),
            .wr_data        (wr_data_i),
            .dec_en         (dec_en[g]),
            .cnt_o          (lc_val[g]),
            .nz_after_dec_o (nz[g])
        );
    end

    seq_op_dec i_dec (
        .fetch     (fetch_i),
        .wr_ip     (wr_ip),
        .wr_lc_hit (wr_hit[loop_sel_i]),
        .loop_req  (loop_req_i),
        .irq       (irq_ack_i),
        .dec_nz    (nz[loop_sel_i]),
        .op        (op),
        .loop_ok   (loop_ok)
    );

    // Next pointer per operation
    always_comb begin
        unique case (op)
            OP_VECTOR:     ip_d = ivec_q + AW'(irq_offs_i);
            OP_LOAD:       ip_d = wr_data_i;
            OP_LOOP_TAKEN: ip_d = loop_target_i;
            OP_LOOP_EXIT:  ip_d = ip_q + AW'(1);
            OP_STEP:       ip_d = ip_q + AW'(1);
            OP_HOLD:       ip_d = ip_q;
            default:       ip_d = ip_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q   <= AW'(RESET_IP);
            ivec_q <= AW'(IVEC_RESET);
        end else begin
            ip_q   <= ip_d;
            ivec_q <= ivec_q;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= 1'b0;
        end else begin
            bt_q <= (op == OP_LOOP_TAKEN);
        end
    end

    assign fetch_addr_o   = ip_q;
    assign lc0_o          = lc_val[0];
    assign lc1_o          = lc_val[1];
    assign ivec_o         = ivec_q;
    assign branch_taken_o = bt_q;

endmodule

// File: rtl/seq_chk.sv
module seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_i,
    input logic        wr_en_i,
    input logic [1:0]  wr_sel_i,
    input logic [15:0] wr_data_i,
    input logic        loop_req_i,
    input logic        loop_sel_i,
    input logic [15:0] loop_target_i,
    input logic        irq_ack_i,
    input logic [3:0]  irq_offs_i,
    input logic [15:0] fetch_addr_o,
    input logic [15:0] lc0_o,
    input logic [15:0] lc1_o,
    input logic [15:0] ivec_o,
    input logic        branch_taken_o
);

    logic [15:0] lc_sel;
    assign lc_sel = loop_sel_i ? lc1_o : lc0_o;

    AST_RESET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (fetch_addr_o == 16'h8000 && !branch_taken_o)); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !wr_en_i && !loop_req_i && !irq_ack_i)
        |=> fetch_addr_o == $past(fetch_addr_o) + 16'd1); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_i && !wr_en_i && !loop_req_i && !irq_ack_i)
        |=> $stable(fetch_addr_o)); // R2

    AST_WRITE_IP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'b00 && !irq_ack_i)
        |=> fetch_addr_o == $past(wr_data_i)); // R3

    AST_VEC_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'b11 && !fetch_i && !loop_req_i && !irq_ack_i)
        |=> ($stable(fetch_addr_o) && $stable(lc0_o) && $stable(lc1_o) && $stable(ivec_o))); // R4

    AST_DEC_LC0: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_req_i && !loop_sel_i && !wr_en_i && !irq_ack_i)
        |=> (lc0_o == $past(lc0_o) - 16'd1 && $stable(lc1_o))); // R5

    AST_LOOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_req_i && !wr_en_i && !irq_ack_i && lc_sel != 16'd1)
        |=> (fetch_addr_o == $past(loop_target_i) && branch_taken_o)); // R6

    AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_req_i && !wr_en_i && !irq_ack_i && lc_sel == 16'd1)
        |=> (fetch_addr_o == $past(fetch_addr_o) + 16'd1 && !branch_taken_o)); // R6

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i |=> fetch_addr_o == $past(ivec_o) + {12'd0, $past(irq_offs_i)}); // R7

    AST_WRITE_BEATS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_req_i && !irq_ack_i && wr_en_i && wr_sel_i == 2'b01 && !loop_sel_i)
        |=> (lc0_o == $past(wr_data_i) && !branch_taken_o)); // R8

endmodule

bind prog_seq seq_chk i_seq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_i        (fetch_i),
    .wr_en_i        (wr_en_i),
    .wr_sel_i       (wr_sel_i),
    .wr_data_i      (wr_data_i),
    .loop_req_i     (loop_req_i),
    .loop_sel_i     (loop_sel_i),
    .loop_target_i  (loop_target_i),
    .irq_ack_i      (irq_ack_i),
    .irq_offs_i     (irq_offs_i),
    .fetch_addr_o   (fetch_addr_o),
    .lc0_o          (lc0_o),
    .lc1_o          (lc1_o),
    .ivec_o         (ivec_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/test_prog_seq.sv
module test_prog_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'b00;
    logic [15:0] wr_data_i = '0;
    logic        loop_req_i = 1'b0;
    logic        loop_sel_i = 1'b0;
    logic [15:0] loop_target_i = '0;
    logic        irq_ack_i = 1'b0;
    logic [3:0]  irq_offs_i = '0;
    logic [15:0] fetch_addr_o, lc0_o, lc1_o, ivec_o;
    logic        branch_taken_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prog_seq i_prog_seq (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .loop_req_i(loop_req_i),
        .loop_sel_i(loop_sel_i), .loop_target_i(loop_target_i),
        .irq_ack_i(irq_ack_i), .irq_offs_i(irq_offs_i),
        .fetch_addr_o(fetch_addr_o), .lc0_o(lc0_o), .lc1_o(lc1_o),
        .ivec_o(ivec_o), .branch_taken_o(branch_taken_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        fetch;
        logic        wr;
        logic [1:0]  sel;
        logic [15:0] wdat;
        logic        lreq;
        logic        lsel;
        logic [15:0] tgt;
        logic        irq;
        logic [3:0]  offs;
        logic [15:0] eip;
        logic [15:0] elc0;
        logic [15:0] elc1;
        logic        ebt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // req fe wr sel wdat      lr ls tgt       irq off  eip       elc0      elc1      bt
        '{4'd2, 1'b1,1'b0,2'b00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h8001,16'h0000,16'h0000,1'b0}, // R2 step
        '{4'd4, 1'b0,1'b1,2'b01,16'h0003, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h8001,16'h0003,16'h0000,1'b0}, // R4 load lc0
        '{4'd4, 1'b1,1'b1,2'b10,16'h0001, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h8002,16'h0003,16'h0001,1'b0}, // R4 load lc1
        '{4'd6, 1'b0,1'b0,2'b00,16'h0000, 1'b1,1'b0,16'h1234, 1'b0,4'h0, 16'h1234,16'h0002,16'h0001,1'b1}, // R6 taken
        '{4'd6, 1'b1,1'b0,2'b00,16'h0000, 1'b1,1'b0,16'h1234, 1'b0,4'h0, 16'h1234,16'h0001,16'h0001,1'b1}, // R6 taken w/ fetch
        '{4'd6, 1'b0,1'b0,2'b00,16'h0000, 1'b1,1'b0,16'h1234, 1'b0,4'h0, 16'h1235,16'h0000,16'h0001,1'b0}, // R6 exit
        '{4'd5, 1'b0,1'b0,2'b00,16'h0000, 1'b1,1'b1,16'h4000, 1'b0,4'h0, 16'h1236,16'h0000,16'h0000,1'b0}, // R5 lc1 exit
        '{4'd5, 1'b0,1'b0,2'b00,16'h0000, 1'b1,1'b1,16'h4000, 1'b0,4'h0, 16'h4000,16'h0000,16'hFFFF,1'b1}, // R5 wrap
        '{4'd3, 1'b1,1'b1,2'b00,16'hFFFF, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'hFFFF,16'h0000,16'hFFFF,1'b0}, // R3 write beats fetch
        '{4'd2, 1'b1,1'b0,2'b00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h0000,16'h0000,16'hFFFF,1'b0}, // R2 wrap
        '{4'd2, 1'b0,1'b0,2'b00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h0000,16'h0000,16'hFFFF,1'b0}, // R2 hold
        '{4'd7, 1'b1,1'b0,2'b00,16'h0000, 1'b1,1'b0,16'h5555, 1'b1,4'h5, 16'h0025,16'h0000,16'hFFFF,1'b0}, // R7 irq drops loop
        '{4'd7, 1'b0,1'b1,2'b00,16'h7777, 1'b0,1'b0,16'h0000, 1'b1,4'hF, 16'h002F,16'h0000,16'hFFFF,1'b0}, // R7 irq beats write
        '{4'd4, 1'b1,1'b1,2'b11,16'h5555, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h0030,16'h0000,16'hFFFF,1'b0}, // R4 vec write ignored
        '{4'd8, 1'b0,1'b1,2'b10,16'h0009, 1'b1,1'b1,16'h3333, 1'b0,4'h0, 16'h0030,16'h0000,16'h0009,1'b0}, // R8 same counter
        '{4'd8, 1'b0,1'b1,2'b00,16'h0100, 1'b1,1'b0,16'h3333, 1'b0,4'h0, 16'h0100,16'h0000,16'h0009,1'b0}, // R8 ip write
        '{4'd5, 1'b0,1'b1,2'b10,16'h0002, 1'b1,1'b0,16'h0200, 1'b0,4'h0, 16'h0200,16'hFFFF,16'h0002,1'b1}, // R5 other counter written
        '{4'd6, 1'b0,1'b0,2'b00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'h0, 16'h0200,16'hFFFF,16'h0002,1'b0}  // R6 flag one cycle
    };

    task automatic check_reset_state(input string tag);
        n_vec++;
        if (fetch_addr_o !== 16'h8000 || lc0_o !== 16'h0000 || lc1_o !== 16'h0000 ||
            ivec_o !== 16'h0020 || branch_taken_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 %s: ip=%h lc0=%h lc1=%h iv=%h bt=%b expected ip=8000 lc0=0000 lc1=0000 iv=0020 bt=0",
                     tag, fetch_addr_o, lc0_o, lc1_o, ivec_o, branch_taken_o);
        end
    endtask

    task automatic idle_inputs();
        fetch_i = 1'b0; wr_en_i = 1'b0; loop_req_i = 1'b0; irq_ack_i = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_reset_state("after release");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fetch_i = VEC[i].fetch;      wr_en_i = VEC[i].wr;
            wr_sel_i = VEC[i].sel;       wr_data_i = VEC[i].wdat;
            loop_req_i = VEC[i].lreq;    loop_sel_i = VEC[i].lsel;
            loop_target_i = VEC[i].tgt;  irq_ack_i = VEC[i].irq;
            irq_offs_i = VEC[i].offs;
            @(posedge clk);
            #1;
            n_vec++;
            if (fetch_addr_o !== VEC[i].eip || lc0_o !== VEC[i].elc0 ||
                lc1_o !== VEC[i].elc1 || branch_taken_o !== VEC[i].ebt) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: ip=%h lc0=%h lc1=%h bt=%b expected ip=%h lc0=%h lc1=%h bt=%b",
                         VEC[i].req, i, fetch_addr_o, lc0_o, lc1_o, branch_taken_o,
                         VEC[i].eip, VEC[i].elc0, VEC[i].elc1, VEC[i].ebt);
            end
        end

        // R4: vector register unchanged after the write attempt
        @(negedge clk);
        idle_inputs();
        n_vec++;
        if (ivec_o !== 16'h0020) begin
            n_bad++;
            $display("FAIL R4 vector register: got %h expected 0020", ivec_o);
        end

        // R1: reset in the middle of a run restores every register
        rst_n = 1'b0;
        #1;
        check_reset_state("mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_reset_state("mid-run release");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule